// File: doc/BRIEF.md
# USB PHY and Controller Bring-Up Sequencer

This block is a finite-state machine that powers up a dual-role USB controller wrapper in a fixed order. A single start strobe launches a run. The run drives the three block resets (PHY, host controller and wrapper control logic), the controller clock divider, the reference-clock and PLL configuration, the PHY power enables and the port-power-control pin settings. It then turns on the interface clock, selects host mode and finally lets the PHY out of reset. The gaps between the reset releases are fixed counts of controller-clock cycles.

The reference configuration is taken from a few plain inputs, all captured when the start strobe is accepted. These inputs are a frequency code, the input the SuperSpeed PLL uses, whether the HighSpeed PLL shares that input or uses its own reference, whether a port-power pin exists, and that pin's polarity. From them the block derives the source-select, frequency-select and PLL multiplier codes. A done flag marks the end of the run. A start strobe that arrives while a run is in progress is ignored, and one that arrives after completion restarts the whole sequence from a clean state.

Top module: `usb_bringup_seq`

## Requirements
- R1: During and after reset every control output is 0, with two exceptions: `role_dev_o` is 1 and `busy_o` and `done_o` are 0.
- R2: A start strobe seen while idle or done asserts `phy_rst_o`, `hc_rst_o` and `ctl_rst_o` together at the next clock edge. At that edge every other control output returns to its reset value, `busy_o` rises and `done_o` falls.
- R3: One edge after the start edge, `clkdiv_rst_o` rises. One edge later, `clkdiv_sel_o` takes the parameter CLKDIV_CODE and `hclk_en_o` rises. One edge after that, `clkdiv_rst_o` falls.
- R4: Four edges after the start edge, one edge applies the whole reference step. It holds `ref_div2_o` at 0, loads source select, frequency select and multiplier, and raises `ssc_en_o`, `ref_ssp_en_o`, `hs_pwr_o` and `ss_pwr_o`.
- R5: `ref_src_sel_o` equals {`hs_own_ref_i`, `ss_src_i`}. Codes 0 and 1 mean both PLLs share input 0 or 1. Codes 2 and 3 mean the SuperSpeed PLL uses input 0 or 1 and the HighSpeed PLL uses its own reference.
- R6: `mpll_mul_o` is 0x19 for `ref_freq_i`=0 (100 MHz), 0x28 for 1 (125 MHz) and 0x32 for 2 (50 MHz). Code 3 is unsupported and falls back to 0x19.
- R7: `ref_fsel_o` is 0x27 when the source-select code is 0 or 1 and the effective frequency is 100 MHz (codes 0 or 3). In every other case it is 0x07.
- R8: `ctl_rst_o` falls exactly WAIT_CYCLES edges after the reference step.
- R9: Another WAIT_CYCLES edges after that, `ppc_en_o` takes `pwr_pin_i` and `ppc_act_high_o` takes the inverse of `pwr_act_low_i`.
- R10: One edge after port power is set, `hc_rst_o` falls. `if_clk_en_o` rises WAIT_CYCLES edges after that, and `role_dev_o` falls one edge later.
- R11: One edge after the role bit clears, `phy_rst_o` falls, `done_o` rises and `busy_o` falls. The outputs then hold until the next start strobe or reset.
- R12: A start strobe while `busy_o` is high has no effect. Changes on the configuration inputs after the accepted strobe have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| ref_freq_i | input | 2 | Reference frequency code (0=100, 1=125, 2=50 MHz, 3=unsupported) |
| ss_src_i | input | 1 | Reference input used by the SuperSpeed PLL |
| hs_own_ref_i | input | 1 | 1: HighSpeed PLL uses its own reference |
| pwr_pin_i | input | 1 | A port-power pin exists |
| pwr_act_low_i | input | 1 | Port-power pin is active-low |
| phy_rst_o | output | 1 | PHY reset |
| hc_rst_o | output | 1 | Host-controller reset |
| ctl_rst_o | output | 1 | Wrapper control-logic reset |
| clkdiv_rst_o | output | 1 | Controller clock divider reset |
| hclk_en_o | output | 1 | Controller clock enable |
| clkdiv_sel_o | output | 3 | Divider ratio code |
| ref_div2_o | output | 1 | Reference pre-divide by 2 |
| ref_src_sel_o | output | 2 | PLL reference source select |
| ref_fsel_o | output | 6 | Reference frequency select |
| mpll_mul_o | output | 7 | PLL multiplier |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ref_ssp_en_o | output | 1 | SuperSpeed prescaler clock enable |
| hs_pwr_o | output | 1 | HighSpeed PHY power |
| ss_pwr_o | output | 1 | SuperSpeed PHY power |
| ppc_en_o | output | 1 | Port power control enable |
| ppc_act_high_o | output | 1 | Port power pin is active-high |
| if_clk_en_o | output | 1 | Interface clock enable |
| role_dev_o | output | 1 | Role bit (1 device, 0 host) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |

## Verification
The bench runs all 64 input configurations back to back and compares every output after every edge of each run. This covers the unsupported frequency code, which would show a zero or wrong multiplier if the fallback were missing. It also covers the 100 MHz shared-source case, the only case that takes 0x27; a design that keyed frequency select on frequency alone would also give 0x27 for separate sources. Each run pulses start in mid-sequence and scrambles the configuration inputs. An unguarded FSM would re-assert the control reset or pick up the new codes. An off-by-one in the wait counter moves the reset releases by one edge and is caught at the exact cycle. Later runs begin from the done state, so a restart that kept stale fields would show early clock enables or power bits.

// File: rtl/usb_bringup_pkg.sv
package usb_bringup_pkg;

  localparam int DIV_W  = 3;
  localparam int SRC_W  = 2;
  localparam int FSEL_W = 6;
  localparam int MUL_W  = 7;
  localparam int FREQ_W = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIV_RST,
    ST_DIV_CFG,
    ST_DIV_REL,
    ST_REF_CFG,
    ST_WAIT_CTL,
    ST_WAIT_PPC,
    ST_HC_REL,
    ST_WAIT_IF,
    ST_ROLE,
    ST_PHY_REL,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic              phy_rst;
    logic              hc_rst;
    logic              ctl_rst;
    logic              div_rst;
    logic              hclk_en;
    logic [DIV_W-1:0]  div_sel;
    logic              ref_div2;
    logic [SRC_W-1:0]  src_sel;
    logic [FSEL_W-1:0] fsel;
    logic [MUL_W-1:0]  mult;
    logic              ssc_en;
    logic              ssp_en;
    logic              hs_pwr;
    logic              ss_pwr;
    logic              ppc_en;
    logic              ppc_high;
    logic              ifclk_en;
    logic              role_dev;
  } ctrl_t;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic              ss_src;
    logic              hs_own;
    logic              pin;
    logic              act_low;
  } cfg_t;

  function automatic ctrl_t ctrl_reset();
    ctrl_t c;
    c = '0;
    c.role_dev = 1'b1;
    return c;
  endfunction

  // Frequency code 3 is unsupported and treated as 100 MHz.
  function automatic logic [MUL_W-1:0] mult_code(input logic [FREQ_W-1:0] f);
    case (f)
      2'd1:    return MUL_W'(7'h28);
      2'd2:    return MUL_W'(7'h32);
      default: return MUL_W'(7'h19);
    endcase
  endfunction

  function automatic logic [SRC_W-1:0] src_code(input logic hs_own, input logic ss_src);
    return {hs_own, ss_src};
  endfunction

  function automatic logic [FSEL_W-1:0] fsel_code(input logic [SRC_W-1:0] src,
                                                  input logic [FREQ_W-1:0] f);
    logic is_100;
    is_100 = (f == 2'd0) || (f == 2'd3);
    return (!src[1] && is_100) ? FSEL_W'(6'h27) : FSEL_W'(6'h07);
  endfunction

endpackage

// File: rtl/usb_bringup_decode.sv
module usb_bringup_decode
  import usb_bringup_pkg::*;
(
  input  cfg_t              cfg_i,
  output logic [SRC_W-1:0]  src_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [MUL_W-1:0]  mult_o
);

  logic [SRC_W-1:0] src_w;

  assign src_w  = src_code(cfg_i.hs_own, cfg_i.ss_src);
  assign src_o  = src_w;
  assign fsel_o = fsel_code(src_w, cfg_i.freq);
  assign mult_o = mult_code(cfg_i.freq);

endmodule

// File: rtl/usb_bringup_timer.sv
module usb_bringup_timer #(
  parameter int WAIT_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);

  localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/usb_bringup_fsm.sv
module usb_bringup_fsm
  import usb_bringup_pkg::*;
#(
  parameter logic [DIV_W-1:0] CLKDIV_CODE = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wait_zero_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic [MUL_W-1:0]  mult_i,
  input  logic              pin_i,
  input  logic              act_low_i,
  output logic              accept_o,
  output logic              wait_load_o,
  output ctrl_t             ctrl_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e st_q, st_d;
  ctrl_t      c_q, c_d;

  always_comb begin
    st_d        = st_q;
    c_d         = c_q;
    accept_o    = 1'b0;
    wait_load_o = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          accept_o  = 1'b1;
          c_d       = ctrl_reset();
          c_d.phy_rst = 1'b1;
          c_d.hc_rst  = 1'b1;
          c_d.ctl_rst = 1'b1;
          st_d      = ST_DIV_RST;
        end
      end
      ST_DIV_RST: begin
        c_d.div_rst = 1'b1;
        st_d        = ST_DIV_CFG;
      end
      ST_DIV_CFG: begin
        c_d.div_sel = CLKDIV_CODE;
        c_d.hclk_en = 1'b1;
        st_d        = ST_DIV_REL;
      end
      ST_DIV_REL: begin
        c_d.div_rst = 1'b0;
        st_d        = ST_REF_CFG;
      end
      ST_REF_CFG: begin
        c_d.ref_div2 = 1'b0;
        c_d.src_sel  = src_i;
        c_d.fsel     = fsel_i;
        c_d.mult     = mult_i;
        c_d.ssc_en   = 1'b1;
        c_d.ssp_en   = 1'b1;
        c_d.hs_pwr   = 1'b1;
        c_d.ss_pwr   = 1'b1;
        wait_load_o  = 1'b1;
        st_d         = ST_WAIT_CTL;
      end
      ST_WAIT_CTL: begin
        if (wait_zero_i) begin
          c_d.ctl_rst = 1'b0;
          wait_load_o = 1'b1;
          st_d        = ST_WAIT_PPC;
        end
      end
      ST_WAIT_PPC: begin
        if (wait_zero_i) begin
          c_d.ppc_en   = pin_i;
          c_d.ppc_high = !act_low_i;
          st_d         = ST_HC_REL;
        end
      end
      ST_HC_REL: begin
        c_d.hc_rst  = 1'b0;
        wait_load_o = 1'b1;
        st_d        = ST_WAIT_IF;
      end
      ST_WAIT_IF: begin
        if (wait_zero_i) begin
          c_d.ifclk_en = 1'b1;
          st_d         = ST_ROLE;
        end
      end
      ST_ROLE: begin
        c_d.role_dev = 1'b0;
        st_d         = ST_PHY_REL;
      end
      ST_PHY_REL: begin
        c_d.phy_rst = 1'b0;
        st_d        = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      c_q  <= ctrl_reset();
    end else begin
      st_q <= st_d;
      c_q  <= c_d;
    end
  end

  assign ctrl_o = c_q;
  assign done_o = (st_q == ST_DONE);
  assign busy_o = (st_q != ST_DONE) && (st_q != ST_IDLE);

endmodule

// File: rtl/usb_bringup_seq.sv
module usb_bringup_seq
  import usb_bringup_pkg::*;
#(
  parameter int                WAIT_CYCLES = 10,
  parameter logic [DIV_W-1:0]  CLKDIV_CODE = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_freq_i,
  input  logic              ss_src_i,
  input  logic              hs_own_ref_i,
  input  logic              pwr_pin_i,
  input  logic              pwr_act_low_i,
  output logic              phy_rst_o,
  output logic              hc_rst_o,
  output logic              ctl_rst_o,
  output logic              clkdiv_rst_o,
  output logic              hclk_en_o,
  output logic [DIV_W-1:0]  clkdiv_sel_o,
  output logic              ref_div2_o,
  output logic [SRC_W-1:0]  ref_src_sel_o,
  output logic [FSEL_W-1:0] ref_fsel_o,
  output logic [MUL_W-1:0]  mpll_mul_o,
  output logic              ssc_en_o,
  output logic              ref_ssp_en_o,
  output logic              hs_pwr_o,
  output logic              ss_pwr_o,
  output logic              ppc_en_o,
  output logic              ppc_act_high_o,
  output logic              if_clk_en_o,
  output logic              role_dev_o,
  output logic              busy_o,
  output logic              done_o
);

  // Named internal events
  logic              start_accept;
  logic              wait_load;
  logic              wait_zero;
  cfg_t              cfg_q;
  logic [SRC_W-1:0]  dec_src;
  logic [FSEL_W-1:0] dec_fsel;
  logic [MUL_W-1:0]  dec_mult;
  ctrl_t             ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (start_accept) begin
      cfg_q <= '{freq: ref_freq_i, ss_src: ss_src_i, hs_own: hs_own_ref_i,
                 pin: pwr_pin_i, act_low: pwr_act_low_i};
    end
  end

  usb_bringup_decode u_decode (
    .cfg_i  (cfg_q),
    .src_o  (dec_src),
    .fsel_o (dec_fsel),
    .mult_o (dec_mult)
  );

  usb_bringup_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_load),
    .zero_o (wait_zero)
  );

  usb_bringup_fsm #(.CLKDIV_CODE(CLKDIV_CODE)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wait_zero_i (wait_zero),
    .src_i       (dec_src),
    .fsel_i      (dec_fsel),
    .mult_i      (dec_mult),
    .pin_i       (cfg_q.pin),
    .act_low_i   (cfg_q.act_low),
    .accept_o    (start_accept),
    .wait_load_o (wait_load),
    .ctrl_o      (ctrl),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign phy_rst_o      = ctrl.phy_rst;
  assign hc_rst_o       = ctrl.hc_rst;
  assign ctl_rst_o      = ctrl.ctl_rst;
  assign clkdiv_rst_o   = ctrl.div_rst;
  assign hclk_en_o      = ctrl.hclk_en;
  assign clkdiv_sel_o   = ctrl.div_sel;
  assign ref_div2_o     = ctrl.ref_div2;
  assign ref_src_sel_o  = ctrl.src_sel;
  assign ref_fsel_o     = ctrl.fsel;
  assign mpll_mul_o     = ctrl.mult;
  assign ssc_en_o       = ctrl.ssc_en;
  assign ref_ssp_en_o   = ctrl.ssp_en;
  assign hs_pwr_o       = ctrl.hs_pwr;
  assign ss_pwr_o       = ctrl.ss_pwr;
  assign ppc_en_o       = ctrl.ppc_en;
  assign ppc_act_high_o = ctrl.ppc_high;
  assign if_clk_en_o    = ctrl.ifclk_en;
  assign role_dev_o     = ctrl.role_dev;

endmodule

// File: rtl/usb_bringup_seq_chk.sv
module usb_bringup_seq_chk #(
  parameter int WAIT_CYCLES = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phy_rst_o,
  input logic       hc_rst_o,
  input logic       ctl_rst_o,
  input logic       clkdiv_rst_o,
  input logic       hclk_en_o,
  input logic [1:0] ref_src_sel_o,
  input logic [5:0] ref_fsel_o,
  input logic [6:0] mpll_mul_o,
  input logic       ss_pwr_o,
  input logic       ppc_en_o,
  input logic       if_clk_en_o,
  input logic       role_dev_o,
  input logic       busy_o,
  input logic       done_o
);

  localparam int GW = $clog2(WAIT_CYCLES + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_ref_q;
  logic [GW-1:0] gap_hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_ref_q <= '0;
      gap_hc_q  <= '0;
    end else begin
      gap_ref_q <= !ss_pwr_o ? '0 : (gap_ref_q == GMAX ? GMAX : gap_ref_q + 1'b1);
      gap_hc_q  <= (hc_rst_o || !phy_rst_o) ? '0 :
                   (gap_hc_q == GMAX ? GMAX : gap_hc_q + 1'b1);
    end
  end

  a_r2_resets_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (phy_rst_o && hc_rst_o && ctl_rst_o && role_dev_o));

  a_r3_div_release_clock_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clkdiv_rst_o) |-> hclk_en_o);

  a_r6_mult_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_pwr_o |-> (mpll_mul_o == 7'h19 || mpll_mul_o == 7'h28 || mpll_mul_o == 7'h32));

  a_r7_fsel_shared_100: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_pwr_o && ref_fsel_o == 6'h27) |-> (!ref_src_sel_o[1] && mpll_mul_o == 7'h19));

  a_r8_ctl_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_rst_o) |-> (gap_ref_q == GW'(WAIT_CYCLES)));

  a_r9_ppc_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ppc_en_o) |-> (!ctl_rst_o && hc_rst_o));

  a_r10_ifclk_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(if_clk_en_o) |-> (gap_hc_q == GW'(WAIT_CYCLES)));

  a_r11_phy_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_rst_o) |-> (!role_dev_o && if_clk_en_o && !hc_rst_o && !ctl_rst_o && done_o));

  a_r11_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

endmodule

bind usb_bringup_seq usb_bringup_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phy_rst_o     (phy_rst_o),
  .hc_rst_o      (hc_rst_o),
  .ctl_rst_o     (ctl_rst_o),
  .clkdiv_rst_o  (clkdiv_rst_o),
  .hclk_en_o     (hclk_en_o),
  .ref_src_sel_o (ref_src_sel_o),
  .ref_fsel_o    (ref_fsel_o),
  .mpll_mul_o    (mpll_mul_o),
  .ss_pwr_o      (ss_pwr_o),
  .ppc_en_o      (ppc_en_o),
  .if_clk_en_o   (if_clk_en_o),
  .role_dev_o    (role_dev_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/usb_bringup_seq_bench.sv
`timescale 1ns/1ps
module usb_bringup_seq_bench;

  localparam int W   = 10;
  localparam int DIV = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] ref_freq_i = '0;
  logic ss_src_i = 1'b0, hs_own_ref_i = 1'b0, pwr_pin_i = 1'b0, pwr_act_low_i = 1'b0;
  logic phy_rst_o, hc_rst_o, ctl_rst_o, clkdiv_rst_o, hclk_en_o;
  logic [2:0] clkdiv_sel_o;
  logic ref_div2_o;
  logic [1:0] ref_src_sel_o;
  logic [5:0] ref_fsel_o;
  logic [6:0] mpll_mul_o;
  logic ssc_en_o, ref_ssp_en_o, hs_pwr_o, ss_pwr_o, ppc_en_o, ppc_act_high_o;
  logic if_clk_en_o, role_dev_o, busy_o, done_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #4 clk_i = ~clk_i;

  usb_bringup_seq #(.WAIT_CYCLES(W), .CLKDIV_CODE(3'(DIV))) u_usb_bringup_seq (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic int exp_mult(input int code);
    int mhz;
    mhz = (code == 1) ? 125 : (code == 2) ? 50 : 100;
    if (mhz == 125) return 40;
    if (mhz == 50)  return 50;
    return 25;
  endfunction

  task automatic check_reset_state(input string req);
    chk(req, "resets", {phy_rst_o, hc_rst_o, ctl_rst_o, clkdiv_rst_o}, 0);
    chk(req, "clock", {hclk_en_o, clkdiv_sel_o, ref_div2_o}, 0);
    chk(req, "refcfg", {ref_src_sel_o, ref_fsel_o, mpll_mul_o}, 0);
    chk(req, "enables", {ssc_en_o, ref_ssp_en_o, hs_pwr_o, ss_pwr_o,
                         ppc_en_o, ppc_act_high_o, if_clk_en_o}, 0);
    chk(req, "role", role_dev_o, 1);
    chk(req, "busy_done", {busy_o, done_o}, 0);
  endtask

  task automatic run_seq(input int idx);
    int fq, ss, own, pin, low, t_ctl, t_ppc, t_hc, t_if, t_role, t_phy, e_src, e_fsel;
    fq = idx & 3; ss = (idx >> 2) & 1; own = (idx >> 3) & 1;
    pin = (idx >> 4) & 1; low = (idx >> 5) & 1;
    t_ctl = 4 + W; t_ppc = 4 + 2*W; t_hc = t_ppc + 1; t_if = t_hc + W;
    t_role = t_if + 1; t_phy = t_role + 1;
    e_src  = own * 2 + ss;
    e_fsel = (own == 0 && (fq == 0 || fq == 3)) ? 'h27 : 'h07;
    @(negedge clk_i);
    ref_freq_i = 2'(fq); ss_src_i = ss[0]; hs_own_ref_i = own[0];
    pwr_pin_i = pin[0]; pwr_act_low_i = low[0]; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k <= t_phy + 3; k++) begin
      if (k == 0) chk("R2", "start_edge", {phy_rst_o, hc_rst_o, ctl_rst_o, busy_o, done_o}, 5'b11110);
      chk("R3", "div_rst", clkdiv_rst_o, (k == 1 || k == 2) ? 1 : 0);
      chk("R3", "hclk_sel", {hclk_en_o, clkdiv_sel_o}, (k >= 2) ? (8 + DIV) : 0);
      chk("R4", "ref_step", {ref_div2_o, ssc_en_o, ref_ssp_en_o, hs_pwr_o, ss_pwr_o},
          (k >= 4) ? 5'b01111 : 0);
      chk("R5 R12", "src_sel", ref_src_sel_o, (k >= 4) ? e_src : 0);
      chk("R6 R12", "mult", mpll_mul_o, (k >= 4) ? exp_mult(fq) : 0);
      chk("R7", "fsel", ref_fsel_o, (k >= 4) ? e_fsel : 0);
      chk("R8", "ctl_rst", ctl_rst_o, (k < t_ctl) ? 1 : 0);
      chk("R9", "ppc", {ppc_en_o, ppc_act_high_o}, (k >= t_ppc) ? (pin*2 + (1 - low)) : 0);
      chk("R10", "hc_rst", hc_rst_o, (k < t_hc) ? 1 : 0);
      chk("R10", "if_clk", if_clk_en_o, (k >= t_if) ? 1 : 0);
      chk("R10", "role", role_dev_o, (k < t_role) ? 1 : 0);
      chk("R11", "phy_rst", phy_rst_o, (k < t_phy) ? 1 : 0);
      chk("R11", "busy_done", {busy_o, done_o}, (k < t_phy) ? 2 : 1);
      if (k == 12) chk("R12", "no_restart", {clkdiv_rst_o, hclk_en_o, ss_pwr_o}, 3'b011);
      if (k == 1) begin
        ref_freq_i = ~ref_freq_i; ss_src_i = ~ss_src_i; hs_own_ref_i = ~hs_own_ref_i;
        pwr_pin_i = ~pwr_pin_i; pwr_act_low_i = ~pwr_act_low_i;
      end
      start_i = (k == 10 || k == 20 || k == t_hc) ? 1'b1 : 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset_state("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("R1");
    for (int i = 0; i < 64; i++) run_seq(i);
    // Start again, then reset mid-sequence.
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk("R2", "busy_mid", busy_o, 1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_reset_state("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_reset_state("R1");
    finish_run();
  end

endmodule